// File: doc/BRIEF.md
# Double-Buffered Timer Period Register

This block holds the period (modulo) value of a 16-bit timer. Software writes the value one byte at a time into a shadow buffer. The buffered value reaches the active period register only at a safe moment. While the timer is stopped, that moment is the write that completes the byte pair. While it runs, the moment is a counter turnaround, and which turnaround counts depends on the counting mode.

The block watches the counter value and direction that the timer core drives. It compares each counter value with the one from the previous clock, so a counter that holds its value for several clocks under a prescaler is seen as a single step. Three kinds of step can trigger a transfer. In edge-aligned mode it is the wrap from the active period to zero. With a free-running counter it is the wrap from all ones to zero. In center-aligned mode it is the first down-count step below the active period. A read port returns the buffered value while a transfer is waiting and the active value otherwise.

Top module: `tpw_period_wbuf`

## Requirements
- R1: After reset the period output, the read data and the pending flag are all zero.
- R2: While the clock select is 00 (stopped), a high-byte write followed by a low-byte write loads {high, low} into the period output one clock after the low-byte strobe, and the pending flag stays 0.
- R3: A pair completes only when a low-byte write follows a high-byte write (or both strobes come in the same cycle). A lone low-byte write, or a high-byte write not yet followed by a low byte, leaves the period output unchanged.
- R4: While the clock select is not 00, a completed pair sets the pending flag one clock after the low-byte strobe. The period output is left unchanged, and the read data shows the buffered value.
- R5: In edge-aligned mode (center bit 0, free-run 0), a pending value is transferred when the counter steps from the active period to 0x0000. The period output changes one clock after the step and pending clears. Any other step to zero, or a counter that holds its value, causes no transfer.
- R6: With free-run 1 and center bit 0, a pending value is transferred only on a step from 0xFFFF to 0x0000. A step from the active period to zero causes no transfer.
- R7: In center-aligned mode (center bit 1), a pending value is transferred only on a step from the active period to the active period minus one with the direction input high (down). A step from the period to zero, or the same step with the direction low, causes no transfer.
- R8: A high-byte write while a value is pending clears the pending flag, so reads return the active period. The following low-byte write completes a new pair, and that new value is the one later transferred.
- R9: If the clock select returns to 00 while a value is pending, the value is transferred on the next clock and pending clears.
- R10: Whenever pending is 0, the read data equals the period output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_hi_i | input | 1 | Strobe: write upper byte of the buffer |
| wr_lo_i | input | 1 | Strobe: write lower byte of the buffer |
| wr_data_i | input | 8 | Byte written by either strobe |
| clk_sel_i | input | 2 | Timer clock select, 00 means stopped |
| center_i | input | 1 | Center-aligned (up/down) counting mode |
| free_run_i | input | 1 | Counter runs over the full 16-bit range |
| cnt_i | input | 16 | Current counter value |
| cnt_down_i | input | 1 | Counter is counting down |
| period_o | output | 16 | Active period value |
| pending_o | output | 1 | A buffered value waits for transfer |
| rd_data_o | output | 16 | Read view: buffer when pending, else active |

## Verification
Each transfer mode gets two counter step patterns. One step is the genuine trigger. The other is a near-miss, such as a wrap to zero from a value that is not the period, the edge-aligned wrap used in free-running mode, or the top turnaround taken with the direction low. A transfer on a near-miss shows that the trigger is decoded wrongly, and a missing transfer on the genuine step shows that the trigger is not recognised. Byte-write orderings are tried with the timer stopped and running: a lone low byte, a lone high byte, a complete pair, and a restarted pair while a value is pending. Together these separate pair tracking from the transfer timing.

// File: rtl/tpw_pkg.sv
package tpw_pkg;

  typedef enum logic [1:0] {
    XM_STOPPED = 2'd0,
    XM_EDGE    = 2'd1,
    XM_FREE    = 2'd2,
    XM_CENTER  = 2'd3
  } xfer_mode_e;

  function automatic xfer_mode_e decode_mode(input logic [1:0] sel,
                                             input logic center,
                                             input logic free_run);
    if (sel == 2'b00) return XM_STOPPED;
    if (center)       return XM_CENTER;
    if (free_run)     return XM_FREE;
    return XM_EDGE;
  endfunction

endpackage

// File: rtl/tpw_byte_buf.sv
module tpw_byte_buf #(
  parameter int BYTE_W = 8,
  localparam int W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [W-1:0]      buf_q,
  output logic [W-1:0]      buf_n,
  output logic              complete
);

  logic hi_seen_q, hi_seen_n;

  // half 0 is the low byte, half 1 the high byte
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic              we;
    logic [BYTE_W-1:0] q;
    assign we = (h == 1) ? wr_hi : wr_lo;
    assign buf_n[h*BYTE_W +: BYTE_W] = we ? wr_data : q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wr_data;
    end
    assign buf_q[h*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    hi_seen_n = hi_seen_q;
    if (wr_lo)      hi_seen_n = 1'b0;
    else if (wr_hi) hi_seen_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_seen_q <= 1'b0;
    else        hi_seen_q <= hi_seen_n;
  end

  assign complete = wr_lo && (hi_seen_q || wr_hi);

endmodule

// File: rtl/tpw_turn_detect.sv
module tpw_turn_detect
  import tpw_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  xfer_mode_e   mode,
  input  logic [W-1:0] cnt,
  input  logic         cnt_down,
  input  logic [W-1:0] period,
  output logic         evt
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ZERO     = {W{1'b0}};

  logic [W-1:0] prev_q;
  logic         run_en;
  logic         stepped;

  assign run_en = (mode != XM_STOPPED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_q <= '0;
    else if (run_en) prev_q <= cnt;
  end

  assign stepped = (prev_q != cnt);

  always_comb begin
    evt = 1'b0;
    unique case (mode)
      XM_EDGE:   evt = stepped && (prev_q == period) && (cnt == ZERO);
      XM_FREE:   evt = stepped && (prev_q == ALL_ONES) && (cnt == ZERO);
      XM_CENTER: evt = stepped && cnt_down && (prev_q == period) &&
                       (cnt == period - 1'b1);
      default:   evt = 1'b0;
    endcase
  end

endmodule

// File: rtl/tpw_xfer_ctrl.sv
module tpw_xfer_ctrl
  import tpw_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  xfer_mode_e   mode,
  input  logic         complete,
  input  logic         restart,
  input  logic         evt,
  input  logic [W-1:0] buf_q,
  input  logic [W-1:0] buf_n,
  output logic [W-1:0] active_q,
  output logic         pending_q
);

  logic [W-1:0] active_n;
  logic         pending_n;
  logic         load_en;

  always_comb begin
    active_n  = active_q;
    pending_n = pending_q;
    load_en   = 1'b0;
    if (mode == XM_STOPPED) begin
      pending_n = 1'b0;
      if (complete) begin
        active_n = buf_n;
        load_en  = 1'b1;
      end else if (pending_q) begin
        active_n = buf_q;
        load_en  = 1'b1;
      end
    end else begin
      if (pending_q && evt && !restart) begin
        active_n  = buf_q;
        load_en   = 1'b1;
        pending_n = 1'b0;
      end
      if (restart)  pending_n = 1'b0;
      if (complete) pending_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       active_q <= '0;
    else if (load_en) active_q <= active_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b0;
    else        pending_q <= pending_n;
  end

endmodule

// File: rtl/tpw_period_wbuf.sv
module tpw_period_wbuf
  import tpw_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [1:0]        clk_sel_i,
  input  logic              center_i,
  input  logic              free_run_i,
  input  logic [W-1:0]      cnt_i,
  input  logic              cnt_down_i,
  output logic [W-1:0]      period_o,
  output logic              pending_o,
  output logic [W-1:0]      rd_data_o
);

  xfer_mode_e   mode;
  logic [W-1:0] buf_q, buf_n;
  logic         complete;
  logic         evt;

  assign mode = decode_mode(clk_sel_i, center_i, free_run_i);

  tpw_byte_buf #(.BYTE_W(BYTE_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hi    (wr_hi_i),
    .wr_lo    (wr_lo_i),
    .wr_data  (wr_data_i),
    .buf_q    (buf_q),
    .buf_n    (buf_n),
    .complete (complete)
  );

  tpw_turn_detect #(.W(W)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .cnt      (cnt_i),
    .cnt_down (cnt_down_i),
    .period   (period_o),
    .evt      (evt)
  );

  tpw_xfer_ctrl #(.W(W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .complete  (complete),
    .restart   (wr_hi_i),
    .evt       (evt),
    .buf_q     (buf_q),
    .buf_n     (buf_n),
    .active_q  (period_o),
    .pending_q (pending_o)
  );

  assign rd_data_o = pending_o ? buf_q : period_o;

endmodule

// File: rtl/tpw_period_wbuf_chk.sv
module tpw_period_wbuf_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_hi_i,
  input logic         wr_lo_i,
  input logic [1:0]   clk_sel_i,
  input logic         center_i,
  input logic         free_run_i,
  input logic [W-1:0] cnt_i,
  input logic [W-1:0] period_o,
  input logic         pending_o,
  input logic [W-1:0] rd_data_o
);

  p_stopped_no_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_i == 2'b00) |=> !pending_o);

  p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_i != 2'b00 && !pending_o) |=> $stable(period_o));

  p_xfer_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pending_o) && !$past(wr_hi_i) && !$past(wr_lo_i))
      |-> (period_o == $past(rd_data_o)));

  p_free_wrap_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_i != 2'b00 && free_run_i && !center_i && pending_o &&
     !wr_hi_i && !wr_lo_i && cnt_i != '0) |=> pending_o);

  p_hi_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi_i && !wr_lo_i) |=> !pending_o);

  p_stop_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_i == 2'b00 && pending_o && !wr_hi_i && !wr_lo_i)
      |=> (period_o == $past(rd_data_o)));

  always_comb begin
    if (rst_n && !pending_o)
      a_read_active_r10: assert (rd_data_o == period_o);
  end

endmodule

bind tpw_period_wbuf tpw_period_wbuf_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_hi_i    (wr_hi_i),
  .wr_lo_i    (wr_lo_i),
  .clk_sel_i  (clk_sel_i),
  .center_i   (center_i),
  .free_run_i (free_run_i),
  .cnt_i      (cnt_i),
  .period_o   (period_o),
  .pending_o  (pending_o),
  .rd_data_o  (rd_data_o)
);

// File: tb/sim_tpw_period_wbuf.sv
module sim_tpw_period_wbuf;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_hi_i, wr_lo_i;
  logic [7:0]  wr_data_i;
  logic [1:0]  clk_sel_i;
  logic        center_i, free_run_i;
  logic [15:0] cnt_i;
  logic        cnt_down_i;
  logic [15:0] period_o;
  logic        pending_o;
  logic [15:0] rd_data_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  tpw_period_wbuf u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hi_i    (wr_hi_i),
    .wr_lo_i    (wr_lo_i),
    .wr_data_i  (wr_data_i),
    .clk_sel_i  (clk_sel_i),
    .center_i   (center_i),
    .free_run_i (free_run_i),
    .cnt_i      (cnt_i),
    .cnt_down_i (cnt_down_i),
    .period_o   (period_o),
    .pending_o  (pending_o),
    .rd_data_o  (rd_data_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_hi(input logic [7:0] d);
    wr_hi_i = 1'b1; wr_data_i = d;
    step();
    wr_hi_i = 1'b0;
  endtask

  task automatic wr_lo(input logic [7:0] d);
    wr_lo_i = 1'b1; wr_data_i = d;
    step();
    wr_lo_i = 1'b0;
  endtask

  task automatic cnt_to(input logic [15:0] v, input logic dn);
    cnt_i = v; cnt_down_i = dn;
    step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_hi_i = 0; wr_lo_i = 0; wr_data_i = 0;
    clk_sel_i = 0; center_i = 0; free_run_i = 0; cnt_i = 0; cnt_down_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R1", "period", period_o, 16'h0000);
    chk("R1", "pending", {15'd0, pending_o}, 16'h0000);
    chk("R1", "rd_data", rd_data_o, 16'h0000);
  endtask

  task automatic t_stopped();
    clk_sel_i = 2'b00;
    wr_hi(8'h12);
    chk("R3", "period after lone high byte", period_o, 16'h0000);
    wr_lo(8'h34);
    chk("R2", "period after pair", period_o, 16'h1234);
    chk("R2", "pending stopped", {15'd0, pending_o}, 16'h0000);
    chk("R10", "rd equals period", rd_data_o, 16'h1234);
  endtask

  task automatic t_edge();
    clk_sel_i = 2'b01; center_i = 0; free_run_i = 0;
    cnt_to(16'h0005, 0);
    wr_hi(8'h00);
    wr_lo(8'h40);
    chk("R4", "pending set", {15'd0, pending_o}, 16'h0001);
    chk("R4", "period held", period_o, 16'h1234);
    chk("R4", "rd shows buffer", rd_data_o, 16'h0040);
    cnt_to(16'h0000, 0);
    chk("R5", "wrap from non-period", period_o, 16'h1234);
    cnt_to(16'h1234, 0);
    cnt_to(16'h1234, 0);
    chk("R5", "held counter", period_o, 16'h1234);
    cnt_to(16'h0000, 0);
    chk("R5", "period after wrap", period_o, 16'h0040);
    chk("R5", "pending cleared", {15'd0, pending_o}, 16'h0000);
  endtask

  task automatic t_free();
    free_run_i = 1;
    wr_hi(8'hAB);
    wr_lo(8'hCD);
    cnt_to(16'h0040, 0);
    cnt_to(16'h0000, 0);
    chk("R6", "period wrap ignored", period_o, 16'h0040);
    cnt_to(16'hFFFF, 0);
    cnt_to(16'h0000, 0);
    chk("R6", "full wrap transfer", period_o, 16'hABCD);
    free_run_i = 0;
  endtask

  task automatic t_center();
    center_i = 1;
    wr_hi(8'h00);
    wr_lo(8'h10);
    cnt_to(16'hABCD, 0);
    cnt_to(16'h0000, 0);
    chk("R7", "zero wrap ignored", period_o, 16'hABCD);
    cnt_to(16'hABCD, 0);
    cnt_to(16'hABCC, 0);
    chk("R7", "up direction ignored", period_o, 16'hABCD);
    cnt_to(16'hABCD, 1);
    cnt_to(16'hABCC, 1);
    chk("R7", "top turnaround", period_o, 16'h0010);
    center_i = 0;
  endtask

  task automatic t_restart();
    cnt_to(16'h0003, 0);
    wr_hi(8'h11);
    wr_lo(8'h22);
    wr_hi(8'h55);
    chk("R8", "pending cleared", {15'd0, pending_o}, 16'h0000);
    chk("R8", "rd shows active", rd_data_o, 16'h0010);
    wr_lo(8'h66);
    chk("R8", "rd new buffer", rd_data_o, 16'h5566);
    cnt_to(16'h0010, 0);
    cnt_to(16'h0000, 0);
    chk("R8", "new value transferred", period_o, 16'h5566);
  endtask

  task automatic t_stop_flush();
    wr_hi(8'h77);
    wr_lo(8'h88);
    chk("R9", "pending before stop", {15'd0, pending_o}, 16'h0001);
    clk_sel_i = 2'b00;
    step();
    chk("R9", "flushed", period_o, 16'h7788);
    chk("R9", "pending clear", {15'd0, pending_o}, 16'h0000);
  endtask

  task automatic t_half();
    clk_sel_i = 2'b00;
    wr_lo(8'h99);
    chk("R3", "lone low byte", period_o, 16'h7788);
    wr_hi(8'h01);
    chk("R3", "lone high byte", period_o, 16'h7788);
    wr_lo(8'h02);
    chk("R3", "pair after lone bytes", period_o, 16'h0102);
  endtask

  initial begin
    t_reset();
    t_stopped();
    t_edge();
    t_free();
    t_center();
    t_restart();
    t_stop_flush();
    t_half();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule